// File: doc/BRIEF.md
# H-Bridge Rectification Gate Controller

This block turns the digital commands of a full-bridge motor driver into four gate enables: a high-side and a low-side switch on each of two legs, A and B. The inputs are the direction, the phase (drive or recirculate), the decay style (fast or slow), the synchronous-rectification setting, two digital current flags and three fault flags.

In the drive phase the block switches on the diagonal pair chosen by the direction. In recirculation it applies one of two decay styles. Fast decay either switches on the opposite diagonal, so the transistors carry the current instead of the body diodes, or switches everything off. Slow decay shorts the winding through the low sides, which acts as a brake when rectification is enabled.

The rectification mode decides when opposite-pair conduction in fast decay stops: on the zero-current flag (active) or on the reverse-current-limit flag (passive). Once stopped, conduction stays off until the next drive phase.

Each leg has its own dead-time counter. A gate that must turn off does so at once. A gate that must turn on waits until its leg has been fully off for a set number of clocks. Fault classes mask either all gates or only the high sides.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: In the drive phase (drive_i=1), dir_i=1 turns on a_hi_o and b_lo_o; dir_i=0 turns on b_hi_o and a_lo_o. All other gates stay off.
- R2: In fast-decay recirculation (drive_i=0, slow_decay_i=0) with rect_cfg_i[1]=1, the diagonal opposite the drive pair conducts: dir_i=1 gives b_hi_o and a_lo_o, and dir_i=0 gives a_hi_o and b_lo_o.
- R3: In fast-decay recirculation with rect_cfg_i[1]=0 (codes 00 and 01), all four gates are off.
- R4: In slow-decay recirculation with rect_cfg_i[1]=1, both low sides are on and both high sides are off.
- R5: In slow-decay recirculation with rect_cfg_i[1]=0, only the low side of the drive pair is on: b_lo_o for dir_i=1, a_lo_o for dir_i=0.
- R6: In active mode (rect_cfg_i=10) during fast decay, zero_cur_i=1 turns all gates off at the next clock edge. They stay off for the rest of that recirculation even after the flag drops. rev_lim_i has no effect in this mode.
- R7: In passive mode (rect_cfg_i=11) during fast decay, rev_lim_i=1 turns all gates off at the next clock edge. They stay off for the rest of that recirculation. zero_cur_i has no effect in this mode.
- R8: In slow decay, zero_cur_i and rev_lim_i have no effect.
- R9: A drive phase clears the stopped state, so the next fast-decay recirculation conducts again.
- R10: A gate that turns on does so only after its leg has had both gates off for DEAD_CYCLES+1 clocks. A gate that turns off does so at the first edge after its command changes.
- R11: ot_fault_i=1 or reg_uv_i=1 turns all gates off at the next clock edge. Normal operation resumes through dead time once the fault clears.
- R12: boost_uv_i=1 turns both high sides off at the next clock edge and leaves the low-side pattern unchanged.
- R13: After reset all gates are off, and the two gates of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Direction: 1 = forward (A high, B low) |
| drive_i | input | 1 | 1 = drive phase, 0 = recirculation |
| slow_decay_i | input | 1 | Recirculation style: 1 = slow, 0 = fast |
| rect_cfg_i | input | 2 | Rectification: bit 1 = enable, bit 0 = passive (1) / active (0) |
| zero_cur_i | input | 1 | Load current has reached zero |
| rev_lim_i | input | 1 | Reverse current has reached the trip limit |
| ot_fault_i | input | 1 | Over-temperature fault |
| reg_uv_i | input | 1 | Low regulator voltage fault |
| boost_uv_i | input | 1 | Low boost-supply fault |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |

## Verification
A sweep applies every combination of direction, phase, decay style, rectification code, current flags and fault flags. Each combination is preceded by one drive cycle and then allowed to settle, and the settled gates are compared with a pattern computed in the bench. This separates the drive, fast-decay and slow-decay tables and shows which current flag each mode responds to. It also shows the two fault masks. Directed sequences then cover what only a sequence can show: the exact edge on which a switched leg turns back on, that the stopped state holds after its flag drops and is cleared by a drive phase, and the one-edge reaction to faults and current flags.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned GATE_HI  = 1;
  localparam int unsigned GATE_LO  = 0;

  typedef enum logic [1:0] {
    RECT_OFF     = 2'd0,
    RECT_ACTIVE  = 2'd1,
    RECT_PASSIVE = 2'd2
  } rect_mode_e;

  // bit 1 enables, bit 0 picks passive over active
  function automatic rect_mode_e decode_rect(input logic [1:0] code);
    if (!code[1])     return RECT_OFF;
    else if (code[0]) return RECT_PASSIVE;
    else              return RECT_ACTIVE;
  endfunction
endpackage

// File: rtl/hb_rect_ctrl.sv
`timescale 1ns/1ps
module hb_rect_ctrl
  import hb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rect_cfg_i,
  input  logic       drive_i,
  input  logic       slow_decay_i,
  input  logic       zero_cur_i,
  input  logic       rev_lim_i,
  output logic       rect_en_o,
  output logic       sr_allow_o
);
  rect_mode_e mode;
  logic       hit;
  logic       stop_q;

  assign mode = decode_rect(rect_cfg_i);

  // end condition only counts in fast-decay recirculation
  assign hit = !drive_i && !slow_decay_i &&
               (((mode == RECT_ACTIVE)  && zero_cur_i) ||
                ((mode == RECT_PASSIVE) && rev_lim_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stop_q <= 1'b0;
    else if (drive_i) stop_q <= 1'b0;
    else if (hit)     stop_q <= 1'b1;
  end

  assign rect_en_o  = (mode != RECT_OFF);
  assign sr_allow_o = rect_en_o && !stop_q && !hit;

  // R9
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |=> !stop_q);

  // R6
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !drive_i) |=> stop_q);
endmodule

// File: rtl/hb_pattern.sv
`timescale 1ns/1ps
module hb_pattern
  import hb_pkg::*;
(
  input  logic                      dir_i,
  input  logic                      drive_i,
  input  logic                      slow_decay_i,
  input  logic                      rect_en_i,
  input  logic                      sr_allow_i,
  input  logic                      kill_all_i,
  input  logic                      kill_hi_i,
  output logic [NUM_LEGS-1:0][1:0]  tgt_o
);
  logic src_leg;  // leg whose high side drives
  logic snk_leg;

  assign src_leg = dir_i ? 1'b0 : 1'b1;
  assign snk_leg = ~src_leg;

  always_comb begin
    tgt_o = '0;
    if (drive_i) begin
      tgt_o[src_leg][GATE_HI] = 1'b1;
      tgt_o[snk_leg][GATE_LO] = 1'b1;
    end else if (slow_decay_i) begin
      if (rect_en_i) begin
        for (int l = 0; l < NUM_LEGS; l++) tgt_o[l][GATE_LO] = 1'b1;
      end else begin
        tgt_o[snk_leg][GATE_LO] = 1'b1;
      end
    end else if (sr_allow_i) begin
      tgt_o[snk_leg][GATE_HI] = 1'b1;
      tgt_o[src_leg][GATE_LO] = 1'b1;
    end
    if (kill_all_i) tgt_o = '0;
    if (kill_hi_i) begin
      for (int l = 0; l < NUM_LEGS; l++) tgt_o[l][GATE_HI] = 1'b0;
    end
  end
endmodule

// File: rtl/hb_leg_dt.sv
`timescale 1ns/1ps
module hb_leg_dt
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] tgt_i,
  output logic [1:0] gate_o
);
  localparam int unsigned CW = $clog2(DEAD_CYCLES + 1) + 1;
  localparam int unsigned IW = $clog2(DEAD_CYCLES + 2) + 1;

  logic [1:0]    gate_q, gate_n, keep;
  logic [CW-1:0] cnt_q, cnt_n;

  assign keep = gate_q & tgt_i;

  always_comb begin
    gate_n = gate_q;
    cnt_n  = cnt_q;
    if (keep != 2'b00) begin
      gate_n = keep;
    end else if (gate_q != 2'b00) begin
      gate_n = 2'b00;                 // turn-off is immediate
      cnt_n  = CW'(DEAD_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_n  = cnt_q - CW'(1);
    end else begin
      gate_n = tgt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 2'b00;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_n;
      cnt_q  <= cnt_n;
    end
  end

  assign gate_o = gate_q;

  // checker state: consecutive all-off cycles, saturating
  logic [IW-1:0] idle_q;
  logic          seen_on_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q    <= '0;
      seen_on_q <= 1'b0;
    end else begin
      seen_on_q <= seen_on_q | (|gate_q);
      if (gate_q != 2'b00)                   idle_q <= '0;
      else if (idle_q < IW'(DEAD_CYCLES + 1)) idle_q <= idle_q + IW'(1);
    end
  end

  // R13
  no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_q[GATE_HI] && gate_q[GATE_LO]));

  // R10
  dead_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_on_q && $rose(|gate_q)) |-> (idle_q >= IW'(DEAD_CYCLES + 1)));

  // R10
  off_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q[GATE_HI] && !tgt_i[GATE_HI]) |=> !gate_q[GATE_HI]);
endmodule

// File: rtl/hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_i,
  input  logic       drive_i,
  input  logic       slow_decay_i,
  input  logic [1:0] rect_cfg_i,
  input  logic       zero_cur_i,
  input  logic       rev_lim_i,
  input  logic       ot_fault_i,
  input  logic       reg_uv_i,
  input  logic       boost_uv_i,
  output logic       a_hi_o,
  output logic       a_lo_o,
  output logic       b_hi_o,
  output logic       b_lo_o
);
  logic                     rect_en, sr_allow;
  logic [NUM_LEGS-1:0][1:0] tgt;
  logic [NUM_LEGS-1:0][1:0] gate;

  hb_rect_ctrl u_rect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rect_cfg_i   (rect_cfg_i),
    .drive_i      (drive_i),
    .slow_decay_i (slow_decay_i),
    .zero_cur_i   (zero_cur_i),
    .rev_lim_i    (rev_lim_i),
    .rect_en_o    (rect_en),
    .sr_allow_o   (sr_allow)
  );

  hb_pattern u_pat (
    .dir_i        (dir_i),
    .drive_i      (drive_i),
    .slow_decay_i (slow_decay_i),
    .rect_en_i    (rect_en),
    .sr_allow_i   (sr_allow),
    .kill_all_i   (ot_fault_i | reg_uv_i),
    .kill_hi_i    (boost_uv_i),
    .tgt_o        (tgt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hb_leg_dt #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tgt_i  (tgt[g]),
      .gate_o (gate[g])
    );
  end

  assign a_hi_o = gate[0][GATE_HI];
  assign a_lo_o = gate[0][GATE_LO];
  assign b_hi_o = gate[1][GATE_HI];
  assign b_lo_o = gate[1][GATE_LO];

  // R11
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_fault_i || reg_uv_i) |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));

  // R12
  boost_hi_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boost_uv_i |=> !(a_hi_o || b_hi_o));

  // R6
  active_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_i && !slow_decay_i && rect_cfg_i == 2'b10 && zero_cur_i)
      |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));

  // R7
  passive_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_i && !slow_decay_i && rect_cfg_i == 2'b11 && rev_lim_i)
      |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));
endmodule

// File: tb/hbridge_gate_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_test;
  localparam int unsigned DT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir, drive, slow, zc, rl, ot, ruv, buv;
  logic [1:0] rect;
  logic a_hi, a_lo, b_hi, b_lo;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  hbridge_gate_ctrl #(.DEAD_CYCLES(DT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .drive_i(drive),
    .slow_decay_i(slow), .rect_cfg_i(rect), .zero_cur_i(zc),
    .rev_lim_i(rl), .ot_fault_i(ot), .reg_uv_i(ruv), .boost_uv_i(buv),
    .a_hi_o(a_hi), .a_lo_o(a_lo), .b_hi_o(b_hi), .b_lo_o(b_lo)
  );

  function automatic logic [3:0] gates();
    return {a_hi, a_lo, b_hi, b_lo};
  endfunction

  // settled pattern {a_hi,a_lo,b_hi,b_lo}, latch assumed clear
  function automatic logic [3:0] model(input logic [9:0] v);
    logic d, dr, sl, zf, rf, of, rf2, bf;
    logic [1:0] rc;
    logic [3:0] e;
    {d, dr, sl, rc, zf, rf, of, rf2, bf} = v;
    if (dr)      e = d ? 4'b1001 : 4'b0110;
    else if (sl) e = rc[1] ? 4'b0101 : (d ? 4'b0001 : 4'b0100);
    else if (rc[1] && !(rc[0] ? rf : zf)) e = d ? 4'b0110 : 4'b1001;
    else         e = 4'b0000;
    if (bf) e = e & 4'b0101;
    if (of || rf2) e = 4'b0000;
    return e;
  endfunction

  function automatic string tag(input logic [9:0] v);
    logic d, dr, sl, zf, rf, of, rf2, bf;
    logic [1:0] rc;
    {d, dr, sl, rc, zf, rf, of, rf2, bf} = v;
    if (of || rf2)      return "R11";
    if (bf)             return "R12";
    if (dr)             return "R1";
    if (sl)             return (zf || rf) ? "R8" : (rc[1] ? "R4" : "R5");
    if (!rc[1])         return "R3";
    if (zf || rf)       return rc[0] ? "R7" : "R6";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic no_shoot();
    n_tests++;
    if ((a_hi && a_lo) || (b_hi && b_lo)) begin
      n_fail++;
      $display("FAIL R13 got=%b exp=no leg with both on", gates());
    end
  endtask

  task automatic apply(input logic [9:0] v);
    @(negedge clk);
    {dir, drive, slow, rect, zc, rl, ot, ruv, buv} = v;
  endtask

  task automatic settle();
    repeat (DT + 6) @(posedge clk);
    #1;
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  initial begin
    {dir, drive, slow, rect, zc, rl, ot, ruv, buv} = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R13", gates(), 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    edge1();
    check("R13", gates(), 4'b0000);

    // sweep every input combination
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] v;
      v = 10'(i);
      apply(v | 10'b01_0000_0000);  // one drive cycle clears stop state
      apply(v);
      settle();
      check(tag(v), gates(), model(v));
      no_shoot();
    end

    // R10: exact dead-time edge, both legs swap
    apply(10'b11_0_00_00000);
    settle();
    check("R1", gates(), 4'b1001);
    apply(10'b01_0_00_00000);
    edge1();
    check("R10", gates(), 4'b0000);
    repeat (DT) edge1();
    check("R10", gates(), 4'b0000);
    edge1();
    check("R10", gates(), 4'b0110);

    // R11: one-edge shutdown and recovery
    apply(10'b11_0_00_00000);
    settle();
    apply(10'b11_0_00_00100);
    edge1();
    check("R11", gates(), 4'b0000);
    apply(10'b11_0_00_00000);
    settle();
    check("R11", gates(), 4'b1001);

    // R12: high sides drop on the next edge, low side stays
    apply(10'b11_0_00_00001);
    edge1();
    check("R12", gates(), 4'b0001);
    apply(10'b11_0_00_00000);
    settle();

    // R6 active mode sequence
    apply(10'b11_0_10_00000);
    settle();
    apply(10'b10_0_10_00000);
    settle();
    check("R2", gates(), 4'b0110);
    apply(10'b10_0_10_01000);
    settle();
    check("R6", gates(), 4'b0110);
    apply(10'b10_0_10_10000);
    edge1();
    check("R6", gates(), 4'b0000);
    apply(10'b10_0_10_00000);
    settle();
    check("R6", gates(), 4'b0000);
    apply(10'b11_0_10_00000);
    settle();
    check("R9", gates(), 4'b1001);
    apply(10'b10_0_10_00000);
    settle();
    check("R9", gates(), 4'b0110);

    // R7 passive mode sequence
    apply(10'b10_0_11_10000);
    settle();
    check("R7", gates(), 4'b0110);
    apply(10'b10_0_11_01000);
    edge1();
    check("R7", gates(), 4'b0000);
    apply(10'b10_0_11_00000);
    settle();
    check("R7", gates(), 4'b0000);

    // R8: flags ignored in slow decay, reverse direction
    apply(10'b01_0_00_00000);
    settle();
    apply(10'b00_1_11_11000);
    settle();
    check("R8", gates(), 4'b0101);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule